// File: doc/BRIEF.md
# Indexed Configuration Port with Upper-Memory Shadow Control

This block is a chipset configuration front end reached through four consecutive byte I/O ports. The first port, at offset 0 from the base (0xEC by default), holds an index. The second port, at offset 1 (0xED), reads and writes the configuration byte that the index selects. The other two ports hold no data. They act as triggers: a read at offset 2 (0xEE) turns the A20 address gate on and a write there turns it off. A read at offset 3 (0xEF) requests a CPU soft reset.

Six of the configuration bytes drive memory attributes for the upper memory area from 0xA0000 to 0xFFFFF, in 16 KB steps. Each step has a 2-bit attribute that tells the memory controller whether reads and writes in that segment go to the expansion bus or to DRAM. Only bytes inside an index window can be written. Index 0 always returns a fixed identification byte.

Top module: `shadow_cfg_port`

## Requirements
- R1: A write to the index port (offset 0) loads the 8-bit index. A read of the index port returns the index while `ioRd` is high in that same cycle, and the new index is visible from the cycle after the write.
- R2: A write to the data port (offset 1) stores the byte only when the index lies in 0x01..0x24 inclusive. When the index is outside that range, the write changes no stored byte and no output.
- R3: A read of the data port returns 0x90 when the index is 0x00. Otherwise it returns the stored byte at the index, and any byte never written reads 0x00.
- R4: Indices 0x0D, 0x0E, 0x0F, 0x10, 0x11 and 0x12 map to segment groups 0xA0000, 0xB0000, 0xC0000, 0xD0000, 0xE0000 and 0xF0000, in that order. Each byte holds four 2-bit fields, bits [1:0] first, for consecutive 16 KB segments. `segAttr[2k+1:2k]` is the attribute of the segment at 0xA0000 + k*0x4000, and it follows a data write from the next cycle.
- R5: Attribute codes are passed through unchanged. 0 means read and write on the bus. 1 means read on the bus and write to DRAM. 2 means read from DRAM and write on the bus. 3 means read and write in DRAM. Bit 0 therefore selects DRAM for writes and bit 1 selects DRAM for reads.
- R6: A read at offset 2 sets `a20Gate` from the next cycle, and a write at offset 2 clears it from the next cycle. A write wins if both happen in the same cycle.
- R7: Each cycle that reads offset 3 gives exactly one cycle of `softRst`, in the following cycle. `softRst` is low in every other cycle.
- R8: `ioRdata` is 0xFF whenever the current cycle is not a read of offset 0 or offset 1. This covers reads of offsets 2 and 3, reads of undecoded addresses, and idle cycles.
- R9: After reset the index is 0x00, every stored byte is 0x00, `segAttr` is all zero, `a20Gate` is low and `softRst` is low.
- R10: Accesses to addresses outside the four ports have no effect on any state or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the current access |
| ioWr | input | 1 | Write strobe, one access per cycle |
| ioRd | input | 1 | Read strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, combinational in the read cycle |
| segAttr | output | 48 | 24 two-bit segment attributes, lowest segment in bits [1:0] |
| a20Gate | output | 1 | A20 gate enable |
| softRst | output | 1 | One-cycle CPU soft-reset request |

## Verification
Read data comes back combinationally in the same cycle as the read strobe. Segment attributes, the index, `a20Gate` and `softRst` each go through one register, so they change in the cycle after the access. The bench drives each access on the falling edge and samples shortly after it. At that point `ioRdata` reflects the access in flight, and the registered outputs reflect every access up to the previous rising edge. The behavioural model therefore compares against its state before it applies the current access, and then applies the access.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  // Strobes decoded by the control path for one I/O cycle
  typedef struct packed {
    logic idxWr;   // load index register
    logic dataWr;  // write addressed config byte (window check in datapath)
    logic selIdx;  // drive index onto read data
    logic selData; // drive addressed config byte onto read data
    logic a20On;   // gate A20 on
    logic a20Off;  // gate A20 off
    logic rstReq;  // request soft reset
  } cfg_strobe_t;

  // Attribute code meaning: bit 0 -> writes to DRAM, bit 1 -> reads from DRAM
  typedef enum logic [1:0] {
    ATTR_BUS_BUS   = 2'd0,
    ATTR_RBUS_WRAM = 2'd1,
    ATTR_RRAM_WBUS = 2'd2,
    ATTR_RAM_RAM   = 2'd3
  } seg_attr_e;

endpackage

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl
  import shadow_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_BASE = 16'h00EC
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  output cfg_strobe_t       strobes
);

  localparam logic [ADDR_W-3:0] BASE_HI = PORT_BASE[ADDR_W-1:2];

  logic       portHit;
  logic [1:0] portOff;

  assign portHit = (ioAddr[ADDR_W-1:2] == BASE_HI);
  assign portOff = ioAddr[1:0];

  always_comb begin
    strobes         = '0;
    strobes.idxWr   = portHit && (portOff == 2'd0) && ioWr;
    strobes.dataWr  = portHit && (portOff == 2'd1) && ioWr;
    strobes.selIdx  = portHit && (portOff == 2'd0) && ioRd;
    strobes.selData = portHit && (portOff == 2'd1) && ioRd;
    strobes.a20Off  = portHit && (portOff == 2'd2) && ioWr;
    strobes.a20On   = portHit && (portOff == 2'd2) && ioRd;
    strobes.rstReq  = portHit && (portOff == 2'd3) && ioRd;
  end

endmodule

// File: rtl/shadow_cfg_dp.sv
module shadow_cfg_dp
  import shadow_cfg_pkg::*;
#(
  parameter logic [7:0] ID_VALUE     = 8'h90,
  parameter logic [7:0] WIN_LO       = 8'h01,
  parameter logic [7:0] WIN_HI       = 8'h24,
  parameter logic [7:0] SHADOW_FIRST = 8'h0D,
  parameter int         SHADOW_REGS  = 6,
  parameter int         SEGS_PER_REG = 4,
  localparam int        SEG_N        = SHADOW_REGS * SEGS_PER_REG
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobes,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic [2*SEG_N-1:0] segAttr,
  output logic              a20Gate,
  output logic              softRst
);

  localparam int WIN_N     = int'(WIN_HI) - int'(WIN_LO) + 1;
  localparam int SHADOW_OF = int'(SHADOW_FIRST) - int'(WIN_LO);

  logic [7:0] idxQ;
  logic [7:0] winQ [WIN_N];
  logic       a20Q;
  logic       rstPulseQ;
  logic [7:0] cfgByte;

  // Index register
  always_ff @(posedge clk) begin
    if (!rstN)               idxQ <= '0;
    else if (strobes.idxWr)  idxQ <= ioWdata;
  end

  // Writable window: only bytes inside the window have storage
  for (genvar i = 0; i < WIN_N; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN)
        winQ[i] <= '0;
      else if (strobes.dataWr && (idxQ == 8'(int'(WIN_LO) + i)))
        winQ[i] <= ioWdata;
    end
  end

  // Addressed byte: ID at zero, stored byte inside window, zero elsewhere
  always_comb begin
    cfgByte = '0;
    if (idxQ == 8'h00) cfgByte = ID_VALUE;
    for (int i = 0; i < WIN_N; i++)
      if (idxQ == 8'(int'(WIN_LO) + i)) cfgByte = winQ[i];
  end

  always_comb begin
    ioRdata = 8'hFF;
    if (strobes.selIdx)       ioRdata = idxQ;
    else if (strobes.selData) ioRdata = cfgByte;
  end

  // Segment attribute fan-out, one 2-bit field per 16 KB segment
  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    localparam int REG_I = SHADOW_OF + k / SEGS_PER_REG;
    localparam int FLD_I = 2 * (k % SEGS_PER_REG);
    seg_attr_e segCode;
    assign segCode          = seg_attr_e'(winQ[REG_I][FLD_I +: 2]);
    assign segAttr[2*k +: 2] = segCode;
  end

  // A20 gate: write (off) has priority over read (on)
  always_ff @(posedge clk) begin
    if (!rstN)               a20Q <= 1'b0;
    else if (strobes.a20Off) a20Q <= 1'b0;
    else if (strobes.a20On)  a20Q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rstPulseQ <= 1'b0;
    else       rstPulseQ <= strobes.rstReq;
  end

  assign a20Gate = a20Q;
  assign softRst = rstPulseQ;

endmodule

// File: rtl/shadow_cfg_port.sv
module shadow_cfg_port
  import shadow_cfg_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] PORT_BASE    = 16'h00EC,
  parameter logic [7:0]  ID_VALUE     = 8'h90,
  parameter logic [7:0]  WIN_LO       = 8'h01,
  parameter logic [7:0]  WIN_HI       = 8'h24,
  parameter logic [7:0]  SHADOW_FIRST = 8'h0D,
  parameter int          SHADOW_REGS  = 6,
  parameter int          SEGS_PER_REG = 4,
  localparam int         ATTR_W       = 2 * SHADOW_REGS * SEGS_PER_REG
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic [ATTR_W-1:0] segAttr,
  output logic              a20Gate,
  output logic              softRst
);

  cfg_strobe_t strobes;

  shadow_cfg_ctrl #(
    .ADDR_W    (ADDR_W),
    .PORT_BASE (PORT_BASE)
  ) u_ctrl (
    .ioAddr  (ioAddr),
    .ioWr    (ioWr),
    .ioRd    (ioRd),
    .strobes (strobes)
  );

  shadow_cfg_dp #(
    .ID_VALUE     (ID_VALUE),
    .WIN_LO       (WIN_LO),
    .WIN_HI       (WIN_HI),
    .SHADOW_FIRST (SHADOW_FIRST),
    .SHADOW_REGS  (SHADOW_REGS),
    .SEGS_PER_REG (SEGS_PER_REG)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ioWdata (ioWdata),
    .ioRdata (ioRdata),
    .segAttr (segAttr),
    .a20Gate (a20Gate),
    .softRst (softRst)
  );

endmodule

// File: rtl/shadow_cfg_chk.sv
module shadow_cfg_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_BASE = 16'h00EC,
  parameter int          ATTR_W    = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [7:0]        ioWdata,
  input logic [7:0]        ioRdata,
  input logic [ATTR_W-1:0] segAttr,
  input logic              a20Gate,
  input logic              softRst
);

  logic atIdx, atData, atGate, atRst;
  assign atIdx  = (ioAddr == ADDR_W'(PORT_BASE));
  assign atData = (ioAddr == ADDR_W'(PORT_BASE + 16'd1));
  assign atGate = (ioAddr == ADDR_W'(PORT_BASE + 16'd2));
  assign atRst  = (ioAddr == ADDR_W'(PORT_BASE + 16'd3));

  AST_IDX_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && atIdx && $past(ioWr && atIdx)) |-> (ioRdata == $past(ioWdata))); // R1

  AST_ID_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && atData && $past(ioWr && atIdx) && $past(ioWdata) == 8'h00) |-> (ioRdata == 8'h90)); // R3

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && atData && $past(ioWr && atIdx) && $past(ioWdata) >= 8'h0D && $past(ioWdata) <= 8'h12)
    |=> (segAttr[8*int'($past(ioWdata, 2) - 8'h0D) +: 8] == $past(ioWdata))); // R4

  AST_A20_ON: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && atGate) |=> a20Gate); // R6

  AST_A20_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && atGate) |=> !a20Gate); // R6

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && atRst) |=> softRst); // R7

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && atRst) |=> !softRst); // R7

  AST_SIDE_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && (atIdx || atData)) |-> (ioRdata == 8'hFF)); // R8

endmodule

bind shadow_cfg_port shadow_cfg_chk #(
  .ADDR_W    (ADDR_W),
  .PORT_BASE (PORT_BASE),
  .ATTR_W    (ATTR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ioAddr  (ioAddr),
  .ioWr    (ioWr),
  .ioRd    (ioRd),
  .ioWdata (ioWdata),
  .ioRdata (ioRdata),
  .segAttr (segAttr),
  .a20Gate (a20Gate),
  .softRst (softRst)
);

// File: tb/tb_shadow_cfg_port.sv
`timescale 1ns/1ps
module tb_shadow_cfg_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0000;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWdata = 8'h00;
  logic [7:0]  ioRdata;
  logic [47:0] segAttr;
  logic        a20Gate;
  logic        softRst;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural reference state
  int mIdx;
  int mMem [256];
  bit mA20;
  bit mRst;

  always #4 clk = ~clk;

  shadow_cfg_port dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .segAttr(segAttr),
    .a20Gate(a20Gate), .softRst(softRst)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [47:0] expAttr();
    logic [47:0] v = '0;
    for (int k = 0; k < 24; k++)
      v[2*k +: 2] = 2'((mMem[8'h0D + k/4] >> (2*(k%4))) & 3);
    return v;
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a, input bit r);
    if (r && a == 16'h00EC) return 8'(mIdx);
    if (r && a == 16'h00ED) return (mIdx == 0) ? 8'h90 : 8'(mMem[mIdx]);
    return 8'hFF;
  endfunction

  // One access: drive on falling edge, compare, then advance the model
  task automatic doOp(input logic [15:0] a, input bit w, input bit r,
                      input logic [7:0] d, input string rdTag);
    @(negedge clk);
    ioAddr = a; ioWr = w; ioRd = r; ioWdata = d;
    #2;
    check(rdTag, ioRdata, expRead(a, r));
    check("R4/R5 segAttr", segAttr, expAttr());
    check("R6 a20Gate", a20Gate, mA20);
    check("R7 softRst", softRst, mRst);
    mRst = 0;
    if (a >= 16'h00EC && a <= 16'h00EF) begin
      if (w && a == 16'h00EC) mIdx = d;
      if (w && a == 16'h00ED && mIdx >= 1 && mIdx <= 8'h24) mMem[mIdx] = d;
      if (r && !w && a == 16'h00EE) mA20 = 1;
      if (w && a == 16'h00EE) mA20 = 0;
      if (r && a == 16'h00EF) mRst = 1;
    end
  endtask

  task automatic idle(input string tag);
    doOp(16'h0000, 0, 0, 8'h00, tag);
  endtask

  task automatic wrCfg(input logic [7:0] idx, input logic [7:0] d);
    doOp(16'h00EC, 1, 0, idx, "R8 idle rdata");
    doOp(16'h00ED, 1, 0, d, "R8 idle rdata");
  endtask

  task automatic rdCfg(input logic [7:0] idx, input string tag);
    doOp(16'h00EC, 1, 0, idx, "R8 idle rdata");
    doOp(16'h00ED, 0, 1, 8'h00, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mIdx = 0; mA20 = 0; mRst = 0;
    for (int i = 0; i < 256; i++) mMem[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R9: reset state
    #2;
    check("R9 segAttr after reset", segAttr, 48'h0);
    check("R9 a20Gate after reset", a20Gate, 0);
    check("R9 softRst after reset", softRst, 0);
    doOp(16'h00EC, 0, 1, 8'h00, "R9 index after reset");
    doOp(16'h00ED, 0, 1, 8'h00, "R3 ID byte after reset");
    rdCfg(8'h24, "R9 stored byte zero after reset");

    // R1: index write and readback
    doOp(16'h00EC, 1, 0, 8'h5A, "R8 idle rdata");
    doOp(16'h00EC, 0, 1, 8'h00, "R1 index readback");
    doOp(16'h00EC, 1, 0, 8'hFF, "R8 idle rdata");
    doOp(16'h00EC, 0, 1, 8'h00, "R1 index readback FF");

    // R2: window boundaries and ignored writes
    wrCfg(8'h01, 8'hA5);  rdCfg(8'h01, "R2 low window edge");
    wrCfg(8'h24, 8'h3C);  rdCfg(8'h24, "R2 high window edge");
    wrCfg(8'h00, 8'h11);  rdCfg(8'h00, "R2 ID not writable");
    wrCfg(8'h25, 8'h77);  rdCfg(8'h25, "R2 above window ignored");
    wrCfg(8'hFF, 8'h77);  rdCfg(8'hFF, "R2 index FF ignored");
    rdCfg(8'h24, "R2 neighbour unchanged");

    // R4/R5: each shadow byte, every code in each field position
    wrCfg(8'h0D, 8'hE4); rdCfg(8'h0D, "R4 group A0000");
    wrCfg(8'h0E, 8'h1B); rdCfg(8'h0E, "R4 group B0000");
    wrCfg(8'h0F, 8'h39); rdCfg(8'h0F, "R5 group C0000");
    wrCfg(8'h10, 8'hC6); rdCfg(8'h10, "R5 group D0000");
    wrCfg(8'h11, 8'hFF); rdCfg(8'h11, "R4 group E0000");
    wrCfg(8'h12, 8'h01); rdCfg(8'h12, "R4 group F0000");
    wrCfg(8'h0C, 8'hFF); idle("R4 neighbour below");
    wrCfg(8'h13, 8'hFF); idle("R4 neighbour above");
    wrCfg(8'h11, 8'h00); idle("R5 clear group");

    // R6: A20 gating
    doOp(16'h00EE, 0, 1, 8'h00, "R8 read EE gives FF");
    idle("R6 after on");
    doOp(16'h00EE, 1, 0, 8'h00, "R8 idle rdata");
    idle("R6 after off");
    doOp(16'h00EE, 0, 1, 8'h00, "R8 read EE gives FF");
    doOp(16'h00EE, 1, 1, 8'h00, "R8 write and read EE");
    idle("R6 write wins");

    // R7: soft reset pulses, single and back to back
    doOp(16'h00EF, 0, 1, 8'h00, "R8 read EF gives FF");
    idle("R7 pulse");
    idle("R7 pulse gone");
    doOp(16'h00EF, 0, 1, 8'h00, "R8 read EF gives FF");
    doOp(16'h00EF, 0, 1, 8'h00, "R8 read EF gives FF");
    idle("R7 back to back");
    doOp(16'h00EF, 1, 0, 8'h00, "R8 idle rdata");
    idle("R7 write EF no pulse");

    // R10: undecoded addresses
    doOp(16'h00E8, 1, 0, 8'h12, "R8 idle rdata");
    doOp(16'h01EC, 1, 0, 8'h12, "R8 idle rdata");
    doOp(16'h00F0, 0, 1, 8'h00, "R10 undecoded read FF");
    doOp(16'h00EC, 0, 1, 8'h00, "R10 index untouched");

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      logic [15:0] a = (sel == 9) ? 16'h00E9 : 16'(16'h00EC + $urandom_range(0, 3));
      int op = $urandom_range(0, 2);
      logic [7:0] d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 8'h2A));
      string tag = (op == 2 && a == 16'h00EC) ? "R1 random" :
                   (op == 2 && a == 16'h00ED) ? "R3 random" :
                   (a == 16'h00E9) ? "R10 random" : "R8 random";
      doOp(a, op == 1, op == 2, d, tag);
    end
    idle("R2 final");
    finish_run();
  end

endmodule